// File: doc/BRIEF.md
# Pattern-Matching Road Finder

This block holds a bank of stored track patterns. Each pattern keeps one coarse bin code (a super bin) for every detector layer. While an event's hits stream in, one bus per layer, every pattern compares each hit against its own word for that layer in the same cycle. When a hit matches, a sticky per-layer flag is set. The search runs while the hits arrive, so no separate search pass is needed after the last hit.

When the end-of-event marker is seen, every pattern whose count of fired layers reaches a programmable threshold counts as a road. The threshold allows majority rules such as "any five of six layers". Roads leave on one shared output bus, one pattern index per cycle, with the lowest index first. A single-cycle end marker follows the last road. In the cycle after that marker, all flags clear, so the next event starts from an empty state. Pattern words are written through a load port, and that port takes effect only while no event is open.

Top module: `am_road_finder`

## Requirements
- R1: After a synchronous active-low reset, all stored words are zero, all layer flags are clear, and `road_vld` and `road_end` are low.
- R2: While no event is open (no hit since the last readout finished), a cycle with `ld_en` high writes `ld_word` into the word of pattern `ld_patt` for layer `ld_layer`.
- R3: A load request while an event is open is ignored. An event is open from its first hit until its readout ends, and it includes the readout cycles.
- R4: A hit on layer l (bit l of `hit_vld`, code in bits `hit_sb[l*SB_W +: SB_W]`) sets the layer-l flag of every pattern whose layer-l word equals the code. Flags stay set until the clear, and a layer's bus affects only that layer's flags.
- R5: At readout, a pattern is a road exactly when its number of set layer flags is greater than or equal to `thresh`.
- R6: Hits presented in the same cycle as `eoe` belong to the event. The first road (or `road_end`, if there are no roads) appears in the cycle right after the `eoe` cycle.
- R7: Roads come out one per cycle on `road_id` with `road_vld` high, in strictly ascending index order, and each road appears exactly once.
- R8: `road_end` is high for one cycle right after the last road. In the next cycle, all flags are clear and a new event or a load may begin.
- R9: Hits arriving during readout do not set any flag and do not add roads.
- R10: With `thresh` equal to zero, every pattern is reported as a road.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_vld | input | NUM_LAYERS | Per-layer hit strobe |
| hit_sb | input | NUM_LAYERS*SB_W | Per-layer super-bin code, layer l in bits l*SB_W upward |
| eoe | input | 1 | End-of-event marker |
| thresh | input | CNT_W | Minimum fired layers for a road; held stable during readout |
| ld_en | input | 1 | Pattern word write strobe |
| ld_patt | input | PIDX_W | Pattern index to write |
| ld_layer | input | LIDX_W | Layer index to write |
| ld_word | input | SB_W | Super-bin code to store |
| road_vld | output | 1 | A road index is on `road_id` |
| road_id | output | PIDX_W | Index of the matched pattern |
| road_end | output | 1 | Readout of the current event is done |

## Verification
Two functions can fall in the same cycle here. The first is the last hit of an event arriving together with `eoe`: the bench always sends its final hit group in the `eoe` cycle and expects those layer flags to count toward the roads. The second is a hit or a load request arriving while roads are already being streamed out. The bench injects a hit group that fully matches a pattern which would otherwise not be a road, and it issues loads during the hit phase and during readout. It then judges the result from the road list of the same event and from the road lists of later events, which would change if any word had been overwritten.

// File: rtl/am_pkg.sv
// Shared types for the road finder.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package am_pkg;
    // Event phase: idle (loads allowed), collecting hits, streaming roads
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HITS = 2'd1,
        PH_READ = 2'd2
    } am_phase_e;
endpackage

// File: rtl/am_pattern_cell.sv
// One stored pattern: a super-bin word per layer, a private comparator per
// layer, a sticky match flag per layer and a fired-layer count against a
// threshold. Assumes the controller gates search_en off during readout and
// pulses clr once when readout ends.
module am_pattern_cell #(
    parameter int NUM_LAYERS = 6,
    parameter int SB_W       = 4,
    parameter int LIDX_W     = 3,
    parameter int CNT_W      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LAYERS-1:0]      hit_vld,
    input  logic [NUM_LAYERS*SB_W-1:0] hit_sb,
    input  logic                       search_en,
    input  logic                       clr,
    input  logic                       ld_we,
    input  logic [LIDX_W-1:0]          ld_layer,
    input  logic [SB_W-1:0]            ld_word,
    input  logic [CNT_W-1:0]           thresh,
    output logic                       road
);
    logic [NUM_LAYERS-1:0] flags;
    logic [CNT_W-1:0]      fired;

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
        logic [SB_W-1:0] word;

        // Store the layer word when this pattern and layer are addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                word <= '0;
            else if (ld_we && ld_layer == LIDX_W'(l))
                word <= ld_word;
        end

        // Sticky flag: set on a matching hit while searching, cleared at end
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                flags[l] <= 1'b0;
            else if (search_en && hit_vld[l] && hit_sb[l*SB_W +: SB_W] == word)
                flags[l] <= 1'b1;
        end
    end

    // Count the fired layers
    always_comb begin
        fired = '0;
        for (int i = 0; i < NUM_LAYERS; i++)
            fired = fired + CNT_W'(flags[i]);
    end

    // Majority decision against the programmable threshold
    assign road = (fired >= thresh);

    // R9
    frozen_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!search_en && !clr) |=> $stable(flags));

    // R8
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == '0));
endmodule

// File: rtl/am_road_encoder.sv
// Priority encoder: grants the lowest-index pending road.
// Assumes req is a plain bit vector; the grant is combinational.
module am_road_encoder #(
    parameter int NUM_PATT = 8,
    parameter int PIDX_W   = 3
) (
    input  logic [NUM_PATT-1:0] req,
    output logic [NUM_PATT-1:0] gnt,
    output logic [PIDX_W-1:0]   idx,
    output logic                any
);
    // Scan from the top so the lowest set bit wins
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = NUM_PATT - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = PIDX_W'(i);
            end
        end
    end

    assign any = |req;

    // Guard the grant shape
    always_comb begin
        // R7
        onehot_grant_chk: assert ($onehot0(gnt));
        // R7
        grant_in_req_chk: assert ((gnt & ~req) == '0);
    end
endmodule

// File: rtl/am_road_finder.sv
// Pattern-matching road finder top. Broadcasts per-layer hits to every
// pattern cell, tracks the event phase, streams roads lowest index first
// and clears the flags after readout. Assumes thresh is stable while
// roads are being read out and eoe during readout is ignored.
module am_road_finder #(
    parameter int NUM_LAYERS = 6,
    parameter int NUM_PATT   = 8,
    parameter int SB_W       = 4,
    localparam int PIDX_W    = (NUM_PATT > 1) ? $clog2(NUM_PATT) : 1,
    localparam int LIDX_W    = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int CNT_W     = $clog2(NUM_LAYERS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LAYERS-1:0]      hit_vld,
    input  logic [NUM_LAYERS*SB_W-1:0] hit_sb,
    input  logic                       eoe,
    input  logic [CNT_W-1:0]           thresh,
    input  logic                       ld_en,
    input  logic [PIDX_W-1:0]          ld_patt,
    input  logic [LIDX_W-1:0]          ld_layer,
    input  logic [SB_W-1:0]            ld_word,
    output logic                       road_vld,
    output logic [PIDX_W-1:0]          road_id,
    output logic                       road_end
);
    import am_pkg::*;

    am_phase_e           phase;
    logic [NUM_PATT-1:0] roads;
    logic [NUM_PATT-1:0] sent;
    logic [NUM_PATT-1:0] pend;
    logic [NUM_PATT-1:0] gnt;
    logic [PIDX_W-1:0]   gidx;
    logic                any_pend;
    logic                in_read;
    logic                clr;
    logic                search_en;

    assign in_read   = (phase == PH_READ);
    assign search_en = !in_read;
    assign clr       = in_read && !any_pend;

    for (genvar p = 0; p < NUM_PATT; p++) begin : g_patt
        logic we;
        // Loads are only honoured for this pattern while idle
        assign we = ld_en && (phase == PH_IDLE) && (ld_patt == PIDX_W'(p));

        am_pattern_cell #(
            .NUM_LAYERS (NUM_LAYERS),
            .SB_W       (SB_W),
            .LIDX_W     (LIDX_W),
            .CNT_W      (CNT_W)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_vld   (hit_vld),
            .hit_sb    (hit_sb),
            .search_en (search_en),
            .clr       (clr),
            .ld_we     (we),
            .ld_layer  (ld_layer),
            .ld_word   (ld_word),
            .thresh    (thresh),
            .road      (roads[p])
        );
    end

    // Roads not yet streamed in this readout
    assign pend = roads & ~sent;

    am_road_encoder #(
        .NUM_PATT (NUM_PATT),
        .PIDX_W   (PIDX_W)
    ) u_enc (
        .req (pend),
        .gnt (gnt),
        .idx (gidx),
        .any (any_pend)
    );

    // Event phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (eoe)        phase <= PH_READ;
                         else if (|hit_vld) phase <= PH_HITS;
                PH_HITS: if (eoe)        phase <= PH_READ;
                PH_READ: if (!any_pend)  phase <= PH_IDLE;
                default:                 phase <= PH_IDLE;
            endcase
        end
    end

    // Remember which roads have already gone out
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sent <= '0;
        else if (in_read)
            sent <= sent | gnt;
    end

    assign road_vld = in_read && any_pend;
    assign road_id  = gidx;
    assign road_end = clr;

    // R7
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (road_vld && $past(road_vld)) |-> (road_id > $past(road_id)));

    // R8
    end_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        road_end |=> (!road_vld && !road_end));

    // R7
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(road_vld && road_end));
endmodule

// File: tb/am_road_finder_test.sv
module am_road_finder_test;
    localparam int L = 6;
    localparam int P = 8;
    localparam int W = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [L-1:0]  hit_vld;
    logic [L*W-1:0] hit_sb;
    logic          eoe;
    logic [2:0]    thresh;
    logic          ld_en;
    logic [2:0]    ld_patt;
    logic [2:0]    ld_layer;
    logic [3:0]    ld_word;
    logic          road_vld;
    logic [2:0]    road_id;
    logic          road_end;

    int errs   = 0;
    int checks = 0;
    int mw [P][L];
    bit mf [P][L];

    am_road_finder #(.NUM_LAYERS(L), .NUM_PATT(P), .SB_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_sb(hit_sb),
        .eoe(eoe), .thresh(thresh), .ld_en(ld_en), .ld_patt(ld_patt),
        .ld_layer(ld_layer), .ld_word(ld_word), .road_vld(road_vld),
        .road_id(road_id), .road_end(road_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wordf(input int p, input int l);
        return (p * 3 + l * 5) % 16;
    endfunction

    task automatic idle_inputs();
        hit_vld = '0; hit_sb = '0; eoe = 1'b0; ld_en = 1'b0;
        ld_patt = '0; ld_layer = '0; ld_word = '0;
    endtask

    // Apply a hit to the model: every pattern with that layer word fires
    task automatic model_hit(input int l, input int v);
        for (int q = 0; q < P; q++)
            if (mw[q][l] == v) mf[q][l] = 1'b1;
    endtask

    function automatic bit model_road(input int q, input int thr);
        int c = 0;
        for (int l = 0; l < L; l++) c += int'(mf[q][l]);
        return c >= thr;
    endfunction

    // Drive one hit group on the given layers with pattern p's words
    task automatic drive_group(input int p, input int nlay);
        for (int l = 0; l < L; l++) begin
            hit_vld[l] = (l < nlay);
            hit_sb[l*W +: W] = 4'(mw[p][l]);
            if (l < nlay) model_hit(l, mw[p][l]);
        end
    endtask

    // Collect and judge the road stream after eoe was driven
    task automatic readout(input int thr, input bit inject, input bit rd_load);
        int nxt = 0;
        int nexp = 0;
        bit done = 1'b0;
        for (int q = 0; q < P; q++) nexp += int'(model_road(q, thr));
        for (int it = 0; it < P + 2 && !done; it++) begin
            @(negedge clk);
            if (it == 0) chk(road_vld == (nexp > 0), "R6 first output after eoe", int'(road_vld), int'(nexp > 0));
            if (road_vld) begin
                int q = nxt;
                while (q < P && !model_road(q, thr)) q++;
                chk(int'(road_id) == q, "R7/R5 road index", int'(road_id), q);
                nxt = int'(road_id) + 1;
            end else if (road_end) begin
                int rest = 0;
                for (int q = nxt; q < P; q++) rest += int'(model_road(q, thr));
                chk(rest == 0, "R5 no road missing at end", rest, 0);
                done = 1'b1;
            end
            idle_inputs();
            if (it == 0 && inject) begin
                // R9: full match for pattern 7 during readout, must be ignored
                for (int l = 0; l < L; l++) begin
                    hit_vld[l] = 1'b1;
                    hit_sb[l*W +: W] = 4'(mw[7][l]);
                end
            end
            if (it == 0 && rd_load) begin
                // R3: load during readout must be ignored
                ld_en = 1'b1; ld_patt = 3'd2; ld_layer = 3'd1; ld_word = 4'd15;
            end
        end
        chk(done, "R8 road_end seen", int'(done), 1);
        @(negedge clk);
        chk(!road_vld && !road_end, "R8 quiet after end", int'(road_vld), 0);
        for (int q = 0; q < P; q++)
            for (int l = 0; l < L; l++) mf[q][l] = 1'b0;
    endtask

    // Event: pattern p fires p%7 layers; the last group arrives with eoe
    task automatic run_event(input int thr, input bit inject, input bit busy_load);
        thresh = 3'(thr);
        for (int p = 0; p < P; p++) begin
            @(negedge clk);
            idle_inputs();
            drive_group(p, p % 7);
            if (p == P - 1) eoe = 1'b1;
            if (busy_load && p == 2) begin
                // R3: load while hits are collecting must be ignored
                ld_en = 1'b1; ld_patt = 3'd1; ld_layer = 3'd0; ld_word = 4'd15;
            end
        end
        readout(thr, inject, busy_load);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; thresh = '0;
        idle_inputs();
        for (int q = 0; q < P; q++)
            for (int l = 0; l < L; l++) begin mw[q][l] = 0; mf[q][l] = 1'b0; end
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk(!road_vld && !road_end, "R1 outputs in reset", int'(road_vld) + int'(road_end), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!road_vld && !road_end, "R1 outputs after reset", int'(road_vld) + int'(road_end), 0);

        // R1: empty event after reset at thr 6 gives no roads (flags clear)
        thresh = 3'd6; eoe = 1'b1;
        readout(6, 1'b0, 1'b0);

        // R2: load all words while idle
        for (int q = 0; q < P; q++)
            for (int l = 0; l < L; l++) begin
                @(negedge clk);
                ld_en = 1'b1; ld_patt = 3'(q); ld_layer = 3'(l);
                ld_word = 4'(wordf(q, l)); mw[q][l] = wordf(q, l);
            end
        @(negedge clk);
        idle_inputs();

        // R4 R5 R6 R7: threshold sweep 6 down to 1; first event also probes R9 and R3
        for (int t = 6; t >= 1; t--)
            run_event(t, t == 6, t == 6);

        // R10: threshold zero reports every pattern
        run_event(0, 1'b0, 1'b0);

        // R2: idle load of a fresh word, then an event hitting only that word
        @(negedge clk);
        ld_en = 1'b1; ld_patt = 3'd7; ld_layer = 3'd0; ld_word = 4'd14; mw[7][0] = 14;
        @(negedge clk);
        idle_inputs();
        thresh = 3'd1;
        hit_vld[0] = 1'b1; hit_sb[3:0] = 4'd14; eoe = 1'b1; model_hit(0, 14);
        readout(1, 1'b0, 1'b0);

        // R8: next event starts clean, no hits gives no roads
        @(negedge clk);
        thresh = 3'd1; eoe = 1'b1;
        readout(1, 1'b0, 1'b0);

        // R4: repeated hits on one layer stay a single flag (count 1 < thr 2)
        @(negedge clk);
        thresh = 3'd2;
        hit_vld[3] = 1'b1; hit_sb[15:12] = 4'(mw[4][3]); model_hit(3, mw[4][3]);
        @(negedge clk);
        eoe = 1'b1;
        readout(2, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule